// File: doc/BRIEF.md
# Command Queue Pause and End-of-Queue Flag Controller

This block keeps the two status flags of a single command queue whose entries go either to a local converter buffer or out to an external device over a serial link. It follows each transfer from start to completion and remembers the entry's destination, its pause bit and its end-of-queue bit. It also follows the selected trigger mode (software, edge or level), the gate input and the triggered status reported by the queue sequencer. From these inputs it raises a pause flag and an end-of-queue flag. It also sends a one-cycle pause request back to the sequencer.

What sets the pause flag depends on the trigger mode. In edge mode it is the completion of an entry that carries a pause bit. In level mode it is a closed gate pulling a triggered queue out of its triggered state. In software mode the flag is never set. A closed gate seen while a transfer is in flight is held back until that transfer completes. A local transfer completes when the buffer reports the entry stored. An external transfer completes when the serial shift ends. Both flags are cleared by writing one. Each flag has an enable, and the enabled flags are ORed into one registered interrupt.

Top module: `cmdq_flag_ctrl`

## Requirements
- R1: In edge mode (`trig_mode` = 1), completing a transfer whose pause bit is set raises `pause_flag` and pulses `pause_req` for one cycle, both visible one cycle after the completion cycle.
- R2: In level mode (`trig_mode` = 2), with no transfer in flight, `q_trig` high and `gate_open` low sets `pause_flag` and pulses `pause_req` one cycle later.
- R3: In software mode (`trig_mode` = 0), `pause_flag` and `pause_req` never rise, neither on a pause-bit entry nor on a closed gate.
- R4: In software or level mode, completing an entry whose pause bit is set changes neither `pause_flag` nor `pause_req`.
- R5: In level mode, a closed gate seen while a transfer is in flight has no effect until that transfer completes. It then takes effect in the completion cycle, even if the gate has reopened in the meantime.
- R6: A transfer to a local buffer (`xfer_dest` = 0) completes only on `local_done`. A transfer to the external device (`xfer_dest` = 1) completes only on `serial_done`. The other done strobe is ignored.
- R7: Completing a transfer whose end-of-queue bit is set raises `eoq_flag` one cycle later, in every trigger mode.
- R8: A write (`wr_en`) with bit 0 of `wr_clr` set clears `pause_flag`, and with bit 1 set clears `eoq_flag`. A zero bit leaves its flag unchanged.
- R9: If a set event and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R10: `irq` equals, one cycle later, (`pause_flag` AND `ie_pause`) OR (`eoq_flag` AND `ie_eoq`).
- R11: During and right after reset, `pause_flag`, `eoq_flag`, `pause_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_mode | input | 2 | 0 software, 1 edge, 2 level |
| gate_open | input | 1 | Gate level, high means open |
| q_trig | input | 1 | Queue is in triggered status |
| xfer_start | input | 1 | A command transfer begins this cycle |
| xfer_dest | input | 1 | 0 local buffer, 1 external device |
| xfer_pause | input | 1 | Pause bit of the starting command |
| xfer_eoq | input | 1 | End-of-queue bit of the starting command |
| local_done | input | 1 | Command stored in local buffer |
| serial_done | input | 1 | Serial transmission finished |
| wr_en | input | 1 | Flag clear write strobe |
| wr_clr | input | 2 | Write-one-to-clear data: bit 0 pause, bit 1 end of queue |
| ie_pause | input | 1 | Pause interrupt enable |
| ie_eoq | input | 1 | End-of-queue interrupt enable |
| pause_flag | output | 1 | Pause flag |
| eoq_flag | output | 1 | End-of-queue flag |
| pause_req | output | 1 | One-cycle pause request to sequencer |
| irq | output | 1 | Combined registered interrupt |

## Verification
`pause_flag`, `eoq_flag` and `pause_req` appear one cycle after the cycle in which the completion strobe or the effective gate closure is presented. `irq` follows one cycle after the flag and enable values it is built from, so it comes two cycles after the event. The driver applies stimulus on the falling edge. Along with it, the driver queues the full expected output state, tagged with the cycle index at which that state must appear. The monitor samples just after each rising edge and compares only the entries due in that cycle. This keeps the latency of each output pinned down exactly. It also means that, for the deferred-gate cases, the absence of an early flag is checked in every cycle while the transfer is still in flight.

// File: rtl/cmdq_pkg.sv
// Package: shared types for the command queue flag controller.
// Assumes a two-bit trigger mode code and a three-field command attribute.
package cmdq_pkg;

    typedef enum logic [1:0] {
        TM_SOFT  = 2'd0,
        TM_EDGE  = 2'd1,
        TM_LEVEL = 2'd2
    } trig_mode_e;

    typedef struct packed {
        logic dest;   // 0 local buffer, 1 external device
        logic pause;
        logic eoq;
    } cmd_attr_t;

    localparam int unsigned FLAG_PAUSE = 0;
    localparam int unsigned FLAG_EOQ   = 1;
    localparam int unsigned NUM_FLAGS  = 2;

endpackage

// File: rtl/cmdq_xfer_track.sv
// Module: follows the single in-flight command transfer.
// It latches the command attributes at start. It reports completion on
// the done strobe that matches the destination, and ignores the other one.
// Assumes at most one transfer in flight. A start is accepted when idle or
// in the completion cycle.
module cmdq_xfer_track
    import cmdq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  cmd_attr_t start_attr,
    input  logic      local_done,
    input  logic      serial_done,
    output logic      busy,
    output logic      done,
    output cmd_attr_t done_attr
);

    logic      busy_q;
    cmd_attr_t attr_q;

    // Completion: pick the strobe that belongs to the latched destination.
    always_comb begin
        done      = busy_q && (attr_q.dest ? serial_done : local_done);
        done_attr = attr_q;
        busy      = busy_q;
    end

    // Track busy state and capture the attributes of a new transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            attr_q <= '0;
        end else if (start && (!busy_q || done)) begin
            busy_q <= 1'b1;
            attr_q <= start_attr;
        end else if (done) begin
            busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cmdq_gate_defer.sv
// Module: decides the cycle in which a closed gate ends the triggered status.
// It acts only in level mode while the queue is triggered. A closure seen
// during a transfer is remembered and applied in that transfer's completion
// cycle.
module cmdq_gate_defer (
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic q_trig,
    input  logic gate_closed,
    input  logic busy,
    input  logic done,
    output logic gate_hit
);

    logic pend_q;
    logic armed;

    // A closure counts only in level mode with the queue triggered.
    always_comb begin
        armed    = level_mode && q_trig;
        gate_hit = armed && (gate_closed || pend_q) && (!busy || done);
    end

    // Hold a closure seen mid-transfer until the transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!armed || gate_hit) begin
            pend_q <= 1'b0;
        end else if (gate_closed && busy && !done) begin
            pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/cmdq_w1c_flag.sv
// Module: a set of sticky flags, cleared by writing one.
// A set wins over a clear arriving in the same cycle.
module cmdq_w1c_flag #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] flag
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic q;
        // Per-bit update: set first, then clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)      q <= 1'b0;
            else if (set[g]) q <= 1'b1;
            else if (clr[g]) q <= 1'b0;
        end
        assign flag[g] = q;
    end

endmodule

// File: rtl/cmdq_flag_ctrl.sv
// Module: top of the pause and end-of-queue flag controller.
// It combines transfer tracking, gate deferral and the flag set, and
// registers the pause request and the interrupt.
// Assumes the sequencer drops q_trig after a pause request.
module cmdq_flag_ctrl
    import cmdq_pkg::*;
#(
    parameter int unsigned MODE_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    trig_mode,
    input  logic                 gate_open,
    input  logic                 q_trig,
    input  logic                 xfer_start,
    input  logic                 xfer_dest,
    input  logic                 xfer_pause,
    input  logic                 xfer_eoq,
    input  logic                 local_done,
    input  logic                 serial_done,
    input  logic                 wr_en,
    input  logic [NUM_FLAGS-1:0] wr_clr,
    input  logic                 ie_pause,
    input  logic                 ie_eoq,
    output logic                 pause_flag,
    output logic                 eoq_flag,
    output logic                 pause_req,
    output logic                 irq
);

    cmd_attr_t            start_attr, done_attr;
    logic                 busy, done, gate_hit, edge_hit, pause_set;
    logic [NUM_FLAGS-1:0] set_vec, clr_vec, flags, ie_vec;
    logic                 preq_q, irq_q;

    // Bundle the starting command's attributes.
    always_comb start_attr = '{dest: xfer_dest, pause: xfer_pause, eoq: xfer_eoq};

    cmdq_xfer_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (xfer_start),
        .start_attr  (start_attr),
        .local_done  (local_done),
        .serial_done (serial_done),
        .busy        (busy),
        .done        (done),
        .done_attr   (done_attr)
    );

    cmdq_gate_defer u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .level_mode  (trig_mode == MODE_W'(TM_LEVEL)),
        .q_trig      (q_trig),
        .gate_closed (!gate_open),
        .busy        (busy),
        .done        (done),
        .gate_hit    (gate_hit)
    );

    // Work out the set and clear vectors for both flags.
    always_comb begin
        edge_hit             = (trig_mode == MODE_W'(TM_EDGE)) && done && done_attr.pause;
        pause_set            = edge_hit || gate_hit;
        set_vec              = '0;
        set_vec[FLAG_PAUSE]  = pause_set;
        set_vec[FLAG_EOQ]    = done && done_attr.eoq;
        clr_vec              = wr_en ? wr_clr : '0;
        ie_vec               = '0;
        ie_vec[FLAG_PAUSE]   = ie_pause;
        ie_vec[FLAG_EOQ]     = ie_eoq;
    end

    cmdq_w1c_flag #(.WIDTH(NUM_FLAGS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_vec),
        .clr   (clr_vec),
        .flag  (flags)
    );

    // Register the pause request pulse and the combined interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preq_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            preq_q <= pause_set;
            irq_q  <= |(flags & ie_vec);
        end
    end

    assign pause_flag = flags[FLAG_PAUSE];
    assign eoq_flag   = flags[FLAG_EOQ];
    assign pause_req  = preq_q;
    assign irq        = irq_q;

endmodule

// File: rtl/cmdq_flag_ctrl_chk.sv
// Checker: temporal properties of the flag controller, bound to the top.
module cmdq_flag_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] trig_mode,
    input logic       wr_en,
    input logic [1:0] wr_clr,
    input logic       ie_pause,
    input logic       ie_eoq,
    input logic       pause_flag,
    input logic       eoq_flag,
    input logic       pause_req,
    input logic       irq
);

    AST_PREQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> pause_flag);  // R1

    AST_SOFT_NO_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == 2'd0 && !pause_flag) |=> !pause_flag);  // R3

    AST_PAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_flag && !(wr_en && wr_clr[0])) |=> pause_flag);  // R8

    AST_EOQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (eoq_flag && !(wr_en && wr_clr[1])) |=> eoq_flag);  // R8

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past((pause_flag && ie_pause) || (eoq_flag && ie_eoq))));  // R10

endmodule

bind cmdq_flag_ctrl cmdq_flag_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_mode  (trig_mode),
    .wr_en      (wr_en),
    .wr_clr     (wr_clr),
    .ie_pause   (ie_pause),
    .ie_eoq     (ie_eoq),
    .pause_flag (pause_flag),
    .eoq_flag   (eoq_flag),
    .pause_req  (pause_req),
    .irq        (irq)
);

// File: tb/cmdq_flag_ctrl_tb_top.sv
// Bench: the driver queues the expected output state with its due cycle,
// and the monitor compares it just after each rising edge.
module cmdq_flag_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] trig_mode = 2'd1;
    logic       gate_open = 1'b1, q_trig = 1'b0;
    logic       xfer_start = 1'b0, xfer_dest = 1'b0, xfer_pause = 1'b0, xfer_eoq = 1'b0;
    logic       local_done = 1'b0, serial_done = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_clr = 2'b00;
    logic       ie_pause = 1'b0, ie_eoq = 1'b0;
    logic       pause_flag, eoq_flag, pause_req, irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done_run = 1'b0;

    typedef struct {
        int    due;
        logic  pf, ef, pr, iq;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;  // 250 MHz

    cmdq_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .gate_open(gate_open),
        .q_trig(q_trig), .xfer_start(xfer_start), .xfer_dest(xfer_dest),
        .xfer_pause(xfer_pause), .xfer_eoq(xfer_eoq), .local_done(local_done),
        .serial_done(serial_done), .wr_en(wr_en), .wr_clr(wr_clr),
        .ie_pause(ie_pause), .ie_eoq(ie_eoq), .pause_flag(pause_flag),
        .eoq_flag(eoq_flag), .pause_req(pause_req), .irq(irq)
    );

    // Monitor: count edges and compare the entries due this cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if ({pause_flag, eoq_flag, pause_req, irq} !== {e.pf, e.ef, e.pr, e.iq}) begin
                    fails++;
                    $display("FAIL %s cycle %0d: pf/ef/pr/irq actual %b%b%b%b expected %b%b%b%b",
                             e.tag, cyc, pause_flag, eoq_flag, pause_req, irq,
                             e.pf, e.ef, e.pr, e.iq);
                end
            end
        end
    end

    // Driver: queue the state expected after the next rising edge.
    task automatic expect_next(input logic pf, ef, pr, iq, input string tag);
        sb.push_back('{due: cyc + 1, pf: pf, ef: ef, pr: pr, iq: iq, tag: tag});
    endtask

    // Driver: move to the next falling edge and drop the strobes.
    task automatic step();
        @(negedge clk);
        xfer_start = 1'b0; local_done = 1'b0; serial_done = 1'b0;
        wr_en = 1'b0; wr_clr = 2'b00;
    endtask

    task automatic start_xfer(input logic dest, pb, eb);
        xfer_start = 1'b1; xfer_dest = dest; xfer_pause = pb; xfer_eoq = eb;
    endtask

    task automatic clear(input logic [1:0] bits);
        wr_en = 1'b1; wr_clr = bits;
    endtask

    // Directed scenarios.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_next(0, 0, 0, 0, "R11 reset state");               step();

        // R1: pause bit in edge mode, local completion
        start_xfer(0, 1, 0); expect_next(0, 0, 0, 0, "R1 in flight"); step();
        local_done = 1'b1;   expect_next(1, 0, 1, 0, "R1 pause set");  step();
        expect_next(1, 0, 0, 0, "R1 request one cycle");           step();

        // R8: write zero keeps the flag, write one clears it
        clear(2'b00); expect_next(1, 0, 0, 0, "R8 zero no effect"); step();
        clear(2'b01); expect_next(0, 0, 0, 0, "R8 clear pause");    step();

        // R6/R7: external entry completes only on serial_done
        start_xfer(1, 0, 1); expect_next(0, 0, 0, 0, "R7 in flight");         step();
        local_done = 1'b1;   expect_next(0, 0, 0, 0, "R6 wrong strobe");      step();
        serial_done = 1'b1;  expect_next(0, 1, 0, 0, "R7 eoq on serial");     step();
        clear(2'b10);        expect_next(0, 0, 0, 0, "R8 clear eoq");         step();

        // R10: interrupt two cycles after the event
        ie_eoq = 1'b1;
        start_xfer(0, 0, 1); expect_next(0, 0, 0, 0, "R10 in flight");     step();
        local_done = 1'b1;   expect_next(0, 1, 0, 0, "R7 eoq local");      step();
        expect_next(0, 1, 0, 1, "R10 irq rises");                           step();
        clear(2'b10);        expect_next(0, 0, 0, 1, "R10 irq lags clear"); step();
        expect_next(0, 0, 0, 0, "R10 irq falls");                           step();
        ie_eoq = 1'b0;

        // R9: set and clear in the same cycle
        start_xfer(0, 0, 1); expect_next(0, 0, 0, 0, "R9 in flight");  step();
        local_done = 1'b1; clear(2'b10);
        expect_next(0, 1, 0, 0, "R9 set wins");                         step();
        clear(2'b10);        expect_next(0, 0, 0, 0, "R9 cleared");     step();

        // R3: software mode ignores the pause bit and the gate
        trig_mode = 2'd0;
        start_xfer(0, 1, 0); expect_next(0, 0, 0, 0, "R3 in flight");   step();
        local_done = 1'b1;   expect_next(0, 0, 0, 0, "R3 pause bit");   step();
        gate_open = 1'b0; q_trig = 1'b1;
        expect_next(0, 0, 0, 0, "R3 closed gate");                      step();
        gate_open = 1'b1;

        // R4: level mode ignores the pause bit
        trig_mode = 2'd2;
        start_xfer(0, 1, 0); expect_next(0, 0, 0, 0, "R4 in flight");   step();
        local_done = 1'b1;   expect_next(0, 0, 0, 0, "R4 pause bit");   step();

        // R2: closed gate while idle
        gate_open = 1'b0;    expect_next(1, 0, 1, 0, "R2 gate closes"); step();
        q_trig = 1'b0;       expect_next(1, 0, 0, 0, "R2 request ends"); step();
        gate_open = 1'b1; clear(2'b01); expect_next(0, 0, 0, 0, "R8 clear"); step();

        // R5: closure during a local transfer, gate reopens before done
        q_trig = 1'b1;
        start_xfer(0, 0, 0); expect_next(0, 0, 0, 0, "R5 in flight");     step();
        gate_open = 1'b0;    expect_next(0, 0, 0, 0, "R5 held back");     step();
        gate_open = 1'b1;    expect_next(0, 0, 0, 0, "R5 still held");    step();
        local_done = 1'b1;   expect_next(1, 0, 1, 0, "R5 local done");    step();
        q_trig = 1'b0;       expect_next(1, 0, 0, 0, "R5 after");         step();
        clear(2'b01);        expect_next(0, 0, 0, 0, "R8 clear");         step();

        // R5/R6: closure during a serial transfer
        q_trig = 1'b1;
        start_xfer(1, 0, 0); expect_next(0, 0, 0, 0, "R5 serial flight"); step();
        gate_open = 1'b0;    expect_next(0, 0, 0, 0, "R5 serial held");   step();
        local_done = 1'b1;   expect_next(0, 0, 0, 0, "R6 wrong strobe");  step();
        serial_done = 1'b1;  expect_next(1, 0, 1, 0, "R5 serial done");   step();
        q_trig = 1'b0; gate_open = 1'b1;
        expect_next(1, 0, 0, 0, "R5 serial after");                       step();

        // R10: pause interrupt enable
        ie_pause = 1'b1;     expect_next(1, 0, 0, 1, "R10 pause irq");    step();
        clear(2'b01);        expect_next(0, 0, 0, 1, "R10 lag");          step();
        expect_next(0, 0, 0, 0, "R10 irq off");                           step();

        step(); step();
        done_run = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int i = 0; i < 5000 && !done_run; i++) @(posedge clk);
        if (!done_run) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        if (sb.size() != 0) begin
            checks++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule